// File: doc/BRIEF.md
# Serial Flash Command Engine

This block runs one serial NOR flash transaction at a time on a single-lane SPI bus. Software places the whole command in a byte-wide transmit queue through a data register: the opcode first, then the address bytes with the most significant byte first, then any program payload. A single write to a control word then starts the transaction. That word also selects the target device, the number of idle clock cycles to insert after the command, and how many response bytes to collect.

The engine lowers the selected chip select and shifts the queued bytes out in SPI mode 0. It then runs the requested idle cycles, clocks in the requested number of response bytes and stores them in a receive queue. Software reads them back through the same data register. A status word reports both queue occupancies, so software detects completion by polling it. A write transaction is complete when the transmit occupancy reaches zero. A read transaction is complete when the receive occupancy equals the requested length.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, the control word reads 0 and the status word reads 0. All chip selects are high and SCLK is low.
- R2: Register offsets are 0x0 for the control word, 0x4 for the status word and 0x8 for the data register. In the status word, the receive occupancy is in bits [9:0], the transmit occupancy is in bits [21:12], and all other bits are 0.
- R3: The control word has soft reset at bit 0, enable at bit 1 and start at bit 2. A transaction starts only when all of these hold: a write changes start from 0 to 1, the same write sets enable and clears soft reset, and the engine is idle. Any other write starts nothing.
- R4: Queued bytes leave in push order, most significant bit first, in SPI mode 0. SCLK idles low, MOSI changes while SCLK is low, and data is sampled on the rising edge. The transmit occupancy drops by one as each byte finishes.
- R5: After the last transmit byte, the engine runs exactly the number of SCLK cycles in control bits [15:8], with MOSI held low.
- R6: The engine then clocks in the number of bytes in control bits [25:16] (0 to 512), most significant bit first, with MOSI low, and pushes them into the receive queue. Each read of the data register pops one byte, in arrival order.
- R7: Control bits [5:4] select the chip select. Values 0 to 2 drive that chip select low from the first SCLK edge until after the last one. Value 3 drives none. At most one chip select is low at any time.
- R8: Each queue holds 512 bytes. Writes to the data register are dropped while a transaction runs or while the transmit queue is full.
- R9: A read of the data register while the receive queue is empty returns 0 and leaves both occupancies unchanged.
- R10: While soft reset is set, both queues are emptied and any running transaction is abandoned, with chip selects high and SCLK low. Data writes and starts are ignored until soft reset is cleared.
- R11: Writing the control word with start clear re-arms the engine, so that a following write with start set begins a new transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of the data register pops a byte |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| spi_cs_n | output | NUM_CS | Active-low chip selects |

## Verification
Most internal faults show up at the status word or on the serial pins within one byte time. A sequencer that skips or repeats a phase changes how many SCLK edges appear between the chip select falling and rising, which a bus monitor counts bit by bit. A wrong queue pointer or count shows up as a status value that differs from the number of bytes pushed, or as a response byte out of order on the first read after completion. A stuck start edge detector is visible within tens of cycles: either the transmit occupancy never drains, or a transaction runs when none was requested.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  localparam logic [3:0] OFS_CTRL   = 4'h0;
  localparam logic [3:0] OFS_STATUS = 4'h4;
  localparam logic [3:0] OFS_DATA   = 4'h8;

  localparam int CTL_SRST  = 0;
  localparam int CTL_EN    = 1;
  localparam int CTL_START = 2;
  localparam int CNT_FLD_W = 10;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_TX    = 2'd1,
    SQ_DUMMY = 2'd2,
    SQ_RX    = 2'd3
  } seq_state_e;

  function automatic logic [1:0] ctl_cs(input logic [31:0] w);
    return w[5:4];
  endfunction

  function automatic logic [7:0] ctl_dummy(input logic [31:0] w);
    return w[15:8];
  endfunction

  function automatic logic [9:0] ctl_rdlen(input logic [31:0] w);
    return w[25:16];
  endfunction

  function automatic logic [31:0] pack_status(input logic [CNT_FLD_W-1:0] rxc,
                                              input logic [CNT_FLD_W-1:0] txc);
    return {10'd0, txc, 2'd0, rxc};
  endfunction

endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int DEPTH = 512,
  parameter int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [7:0]       din,
  input  logic             pop,
  output logic [7:0]       dout,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));
  assign dout  = mem[rptr];

  wire do_push = push && !full;
  wire do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= bump(wptr);
      if (do_pop)  rptr <= bump(rptr);
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/spi_bit_shifter.sv
module spi_bit_shifter #(
  parameter int HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       abort,
  input  logic       go,
  input  logic [7:0] tx_byte,
  input  logic [3:0] nbits,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_byte
);
  localparam int TW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [TW-1:0] tmr;
  logic [7:0]    sh;
  logic [3:0]    left;

  wire phase_end = (tmr == TW'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr <= '0; sh <= '0; left <= '0; rx_byte <= '0;
      sclk <= 1'b0; mosi <= 1'b0; busy <= 1'b0; done <= 1'b0;
    end else if (abort) begin
      tmr <= '0; sclk <= 1'b0; mosi <= 1'b0; busy <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (go) begin
          busy <= 1'b1;
          sh   <= tx_byte;
          mosi <= tx_byte[7];
          left <= nbits;
          tmr  <= '0;
          sclk <= 1'b0;
        end
      end else if (!phase_end) begin
        tmr <= tmr + 1'b1;
      end else begin
        tmr <= '0;
        if (!sclk) begin
          sclk    <= 1'b1;
          rx_byte <= {rx_byte[6:0], miso};
        end else begin
          sclk <= 1'b0;
          if (left == 4'd1) begin
            busy <= 1'b0;
            done <= 1'b1;
            mosi <= 1'b0;
          end else begin
            left <= left - 1'b1;
            sh   <= {sh[6:0], 1'b0};
            mosi <= sh[6];
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_seq_ctrl.sv
module spi_seq_ctrl
  import spi_eng_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       abort,
  input  logic       start,
  input  logic [1:0] start_cs,
  input  logic [7:0] start_dummy,
  input  logic [9:0] start_rdlen,
  input  logic       tx_empty,
  input  logic [7:0] tx_head,
  input  logic       sh_done,
  output logic       tx_pop,
  output logic       rx_push,
  output logic       sh_go,
  output logic [7:0] sh_byte,
  output logic [3:0] sh_nbits,
  output logic       busy,
  output logic       in_readback,
  output logic [1:0] cs_sel
);
  seq_state_e state;
  logic       inflight;
  logic [7:0] dleft;
  logic [9:0] rleft;

  always_comb begin
    sh_go    = 1'b0;
    sh_byte  = 8'd0;
    sh_nbits = 4'd8;
    unique case (state)
      SQ_TX: begin
        sh_go   = !inflight && !tx_empty;
        sh_byte = tx_head;
      end
      SQ_DUMMY: begin
        sh_go    = !inflight && (dleft != 8'd0);
        sh_nbits = 4'd1;
      end
      SQ_RX:   sh_go = !inflight && (rleft != 10'd0);
      default: sh_go = 1'b0;
    endcase
  end

  assign tx_pop      = (state == SQ_TX) && sh_done;
  assign rx_push     = (state == SQ_RX) && sh_done;
  assign busy        = (state != SQ_IDLE);
  assign in_readback = (state == SQ_DUMMY) || (state == SQ_RX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_IDLE; inflight <= 1'b0;
      dleft <= '0; rleft <= '0; cs_sel <= '0;
    end else if (abort) begin
      state <= SQ_IDLE; inflight <= 1'b0;
    end else begin
      if (sh_go)   inflight <= 1'b1;
      if (sh_done) inflight <= 1'b0;
      unique case (state)
        SQ_IDLE: if (start) begin
          state  <= SQ_TX;
          dleft  <= start_dummy;
          rleft  <= start_rdlen;
          cs_sel <= start_cs;
        end
        SQ_TX:    if (!inflight && tx_empty) state <= SQ_DUMMY;
        SQ_DUMMY: begin
          if (sh_done) dleft <= dleft - 1'b1;
          if (!inflight && dleft == 8'd0) state <= SQ_RX;
        end
        SQ_RX: begin
          if (sh_done) rleft <= rleft - 1'b1;
          if (!inflight && rleft == 10'd0) state <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_eng_pkg::*;
#(
  parameter int FIFO_DEPTH = 512,
  parameter int CLK_DIV    = 4,
  parameter int NUM_CS     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_cs_n
);
  localparam int CNT_W = $clog2(FIFO_DEPTH) + 1;
  localparam int HALF  = (CLK_DIV >= 2) ? CLK_DIV / 2 : 1;

  logic [31:0]      ctl_q;
  logic [CNT_W-1:0] tx_cnt, rx_cnt;
  logic             tx_empty, tx_full, rx_empty, rx_full;
  logic [7:0]       tx_head, rx_head, sh_rx;
  logic             tx_pop, rx_push, sh_go, sh_done, sh_busy;
  logic [7:0]       sh_byte;
  logic [3:0]       sh_nbits;
  logic             seq_busy, in_readback;
  logic [1:0]       cs_sel;
  logic [NUM_CS-1:0] cs_q;

  // Named internal events, also used by the bound checker
  wire flush       = ctl_q[CTL_SRST];
  wire ctl_wr      = reg_wr && (reg_addr == OFS_CTRL);
  wire data_wr_req = reg_wr && (reg_addr == OFS_DATA);
  wire start_evt   = ctl_wr && reg_wdata[CTL_START] && !ctl_q[CTL_START]
                     && reg_wdata[CTL_EN] && !reg_wdata[CTL_SRST]
                     && !flush && !seq_busy;
  wire data_wr_evt = data_wr_req && !seq_busy && !flush && !tx_full;
  wire data_rd_evt = reg_rd && (reg_addr == OFS_DATA) && !rx_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_wr) ctl_q <= reg_wdata;
  end

  always_comb begin
    unique case (reg_addr)
      OFS_CTRL:   reg_rdata = ctl_q;
      OFS_STATUS: reg_rdata = pack_status(CNT_FLD_W'(rx_cnt), CNT_FLD_W'(tx_cnt));
      OFS_DATA:   reg_rdata = rx_empty ? 32'd0 : {24'd0, rx_head};
      default:    reg_rdata = 32'd0;
    endcase
  end

  spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(data_wr_evt), .din(reg_wdata[7:0]), .pop(tx_pop),
    .dout(tx_head), .count(tx_cnt), .empty(tx_empty), .full(tx_full));

  spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(rx_push), .din(sh_rx), .pop(data_rd_evt),
    .dout(rx_head), .count(rx_cnt), .empty(rx_empty), .full(rx_full));

  spi_seq_ctrl u_seq (
    .clk(clk), .rst_n(rst_n), .abort(flush), .start(start_evt),
    .start_cs(ctl_cs(reg_wdata)), .start_dummy(ctl_dummy(reg_wdata)),
    .start_rdlen(ctl_rdlen(reg_wdata)),
    .tx_empty(tx_empty), .tx_head(tx_head), .sh_done(sh_done),
    .tx_pop(tx_pop), .rx_push(rx_push), .sh_go(sh_go), .sh_byte(sh_byte),
    .sh_nbits(sh_nbits), .busy(seq_busy), .in_readback(in_readback),
    .cs_sel(cs_sel));

  spi_bit_shifter #(.HALF(HALF)) u_shf (
    .clk(clk), .rst_n(rst_n), .abort(flush), .go(sh_go),
    .tx_byte(sh_byte), .nbits(sh_nbits), .miso(spi_miso),
    .sclk(spi_sclk), .mosi(spi_mosi), .busy(sh_busy), .done(sh_done),
    .rx_byte(sh_rx));

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cs_q[i] <= 1'b1;
      else if (flush) cs_q[i] <= 1'b1;
      else            cs_q[i] <= !(seq_busy && cs_sel == 2'(i));
    end
  end
  assign spi_cs_n = cs_q;

  // Full flag of the receive queue only gates pushes inside the queue
  wire unused_ok = rx_full & sh_busy;
endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk #(
  parameter int DEPTH = 512,
  parameter int CS_N  = 3,
  parameter int CNT_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CS_N-1:0]  cs_n,
  input logic             sclk,
  input logic             mosi,
  input logic             flush,
  input logic             seq_busy,
  input logic             in_readback,
  input logic             start_evt,
  input logic             data_wr_req,
  input logic [CNT_W-1:0] tx_cnt,
  input logic [CNT_W-1:0] rx_cnt
);
  p_one_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1);

  p_sclk_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_busy |-> !sclk);

  p_mosi_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_readback |-> !mosi);

  p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (tx_cnt == '0 && rx_cnt == '0 && (&cs_n) && !seq_busy && !sclk));

  p_busy_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr_req && seq_busy) |=> (tx_cnt <= $past(tx_cnt)));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= CNT_W'(DEPTH)) && (rx_cnt <= CNT_W'(DEPTH)));

  p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> seq_busy);
endmodule

bind spi_cmd_engine spi_cmd_engine_chk #(.DEPTH(FIFO_DEPTH), .CS_N(NUM_CS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sclk(spi_sclk), .mosi(spi_mosi),
  .flush(flush), .seq_busy(seq_busy), .in_readback(in_readback),
  .start_evt(start_evt), .data_wr_req(data_wr_req),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt));

// File: tb/spi_cmd_engine_tb.sv
`timescale 1ns/1ps
module spi_cmd_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        spi_sclk, spi_mosi, spi_miso;
  logic [2:0]  spi_cs_n;

  int checks = 0, fails = 0;
  int nbits = 0, rd_base = 0;
  logic cap [0:8191];
  logic [7:0] txb [0:15];

  always #2 clk = ~clk;

  spi_cmd_engine u_dut (.*);

  function automatic logic [7:0] resp(input int j);
    return 8'((j * 29 + 90) ^ (j >> 3));
  endfunction

  function automatic logic miso_bit(input int n, input int base);
    int idx = n - base;
    if (idx < 0) return 1'b0;
    return resp(idx / 8)[7 - (idx % 8)];
  endfunction

  function automatic logic [31:0] ctl_word(input int cs, input int dm, input int rb,
                                           input bit en, input bit go);
    return (32'(rb) << 16) | (32'(dm) << 8) | (32'(cs) << 4) |
           (32'(go) << 2) | (32'(en) << 1);
  endfunction

  assign spi_miso = miso_bit(nbits, rd_base);
  wire cs_all_hi = &spi_cs_n;

  // Flash model: records MOSI on rising SCLK, restarts at chip select fall
  always @(posedge spi_sclk or negedge cs_all_hi) begin
    if (spi_sclk) begin
      if (nbits < 8192) cap[nbits] = spi_mosi;
      nbits = nbits + 1;
    end else nbits = 0;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wait_tx_zero();
    logic [31:0] st;
    for (int k = 0; k < 4000; k++) begin
      reg_read(4'h4, st);
      if (st[21:12] == 0 && cs_all_hi) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic run_txn(input int cs, input int ntx, input int dm, input int rb,
                         input bit inject);
    logic [31:0] st, d;
    logic [2:0]  lowseen = 3'b000;
    int          bad;
    rd_base = 8 * ntx + dm;
    for (int i = 0; i < ntx; i++) begin
      txb[i] = 8'($urandom);
      reg_write(4'h8, {24'd0, txb[i]});
    end
    reg_write(4'h0, ctl_word(cs, dm, rb, 1'b1, 1'b1));
    if (inject) reg_write(4'h8, 32'hEE);
    for (int k = 0; k < 20000; k++) begin
      reg_read(4'h4, st);
      lowseen |= ~spi_cs_n;
      if (st[21:12] == 0 && int'(st[9:0]) == rb && cs_all_hi) break;
    end
    repeat (4) @(negedge clk);
    reg_read(4'h4, st);
    chk(st[21:12] == 0, "R4 tx occupancy drained", int'(st[21:12]), 0);
    chk(int'(st[9:0]) == rb, "R6 rx occupancy equals length", int'(st[9:0]), rb);
    chk(lowseen == ((cs < 3) ? (3'b001 << cs) : 3'b000), "R7 chip select",
        int'(lowseen), (cs < 3) ? (1 << cs) : 0);
    if (cs < 3) begin
      chk(nbits == 8 * ntx + dm + 8 * rb, "R5 SCLK edge count", nbits, 8 * ntx + dm + 8 * rb);
      bad = -1;
      for (int i = 0; i < 8 * ntx; i++)
        if (bad < 0 && cap[i] !== txb[i / 8][7 - (i % 8)]) bad = i;
      chk(bad < 0, "R4 transmit bit order", bad, -1);
      bad = -1;
      for (int i = 8 * ntx; i < nbits && i < 8192; i++)
        if (bad < 0 && cap[i] !== 1'b0) bad = i;
      chk(bad < 0, "R5 MOSI low in dummy and read phases", bad, -1);
      for (int j = 0; j < rb; j++) begin
        reg_read(4'h8, d);
        chk(d == {24'd0, resp(j)}, "R6 read-back byte", int'(d), int'(resp(j)));
      end
    end
    reg_write(4'h0, ctl_word(0, 0, 0, 1'b1, 1'b0));
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    reg_read(4'h4, v); chk(v == 0, "R1 status after reset", int'(v), 0);
    reg_read(4'h0, v); chk(v == 0, "R1 control after reset", int'(v), 0);
    chk(cs_all_hi && !spi_sclk, "R1 pins idle", int'(spi_cs_n), 7);
    reg_read(4'h8, v); chk(v == 0, "R9 empty data read", int'(v), 0);
    reg_read(4'h4, v); chk(v == 0, "R9 counts unchanged", int'(v), 0);

    run_txn(0, 4, 0, 0, 1'b0);
    run_txn(1, 5, 8, 4, 1'b0);
    run_txn(2, 6, 0, 0, 1'b0);
    run_txn(2, 1, 0, 2, 1'b1);          // R8 data write while busy
    reg_read(4'h8, v); chk(v == 0, "R9 data read after drain", int'(v), 0);
    run_txn(3, 2, 0, 0, 1'b0);          // R7 index 3 selects nothing

    // R3 start without a 0->1 edge, then R11 re-arm
    reg_write(4'h8, 32'h9F);
    reg_write(4'h0, ctl_word(0, 0, 0, 1'b1, 1'b1));
    wait_tx_zero();
    reg_write(4'h8, 32'h05);
    reg_write(4'h0, ctl_word(0, 0, 0, 1'b1, 1'b1));
    repeat (50) @(negedge clk);
    reg_read(4'h4, v); chk(v[21:12] == 1, "R3 start held high is not a new edge", int'(v[21:12]), 1);
    reg_write(4'h0, ctl_word(0, 0, 0, 1'b1, 1'b0));
    reg_write(4'h0, ctl_word(0, 0, 0, 1'b1, 1'b1));
    wait_tx_zero();
    reg_read(4'h4, v); chk(v[21:12] == 0, "R11 re-armed start runs", int'(v[21:12]), 0);
    reg_write(4'h0, ctl_word(0, 0, 0, 1'b1, 1'b0));

    // R3 start with enable clear
    reg_write(4'h0, 32'd0);
    reg_write(4'h8, 32'h06);
    reg_write(4'h0, ctl_word(0, 0, 0, 1'b0, 1'b1));
    repeat (50) @(negedge clk);
    reg_read(4'h4, v); chk(v[21:12] == 1, "R3 start ignored without enable", int'(v[21:12]), 1);
    reg_write(4'h0, ctl_word(0, 0, 0, 1'b1, 1'b0));
    reg_write(4'h0, ctl_word(0, 0, 0, 1'b1, 1'b1));
    wait_tx_zero();
    reg_write(4'h0, ctl_word(0, 0, 0, 1'b1, 1'b0));

    // R8 capacity and R2 field position, then R10 flush
    for (int i = 0; i < 513; i++) reg_write(4'h8, 32'(i));
    reg_read(4'h4, v); chk(v == 32'h0020_0000, "R8 R2 transmit queue full at 512", int'(v), 32'h0020_0000);
    reg_write(4'h0, 32'h1);
    reg_write(4'h8, 32'h33);
    reg_read(4'h4, v); chk(v == 0, "R10 flush empties queues", int'(v), 0);
    reg_write(4'h0, 32'h2);
    reg_read(4'h4, v); chk(v == 0, "R10 data write during flush ignored", int'(v), 0);

    // R10 abort of a running transaction
    reg_write(4'h8, 32'h0B);
    reg_write(4'h8, 32'h00);
    reg_write(4'h0, ctl_word(0, 200, 4, 1'b1, 1'b1));
    repeat (30) @(negedge clk);
    chk(!cs_all_hi, "R7 chip select low during transaction", int'(spi_cs_n), 6);
    reg_write(4'h0, 32'h1);
    repeat (2) @(negedge clk);
    chk(cs_all_hi && !spi_sclk, "R10 abort releases bus", int'(spi_cs_n), 7);
    reg_read(4'h4, v); chk(v == 0, "R10 abort counts", int'(v), 0);
    reg_write(4'h0, 32'h2);

    run_txn(0, 1, 0, 512, 1'b0);         // R6 maximum read-back length

    for (int t = 0; t < 8; t++)
      run_txn(int'($urandom_range(2, 0)), int'($urandom_range(6, 1)),
              int'($urandom_range(9, 0)), int'($urandom_range(6, 0)), 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule